// File: doc/BRIEF.md
# Interruption Entry Sequencer

This block carries out the hardware side of taking an interruption. A request names an exception number. The block records the machine state that existed before the interruption: the status word, the front and back instruction offsets, and the front and back space identifiers. When the old status word allows it, the block also records the instruction word that caused the fault and copies seven general registers into a shadow bank. It then writes a fixed status word and steers the instruction address queue to a vector slot.

The requester holds `req_valid` and the exception number steady until it sees the one-cycle `req_ack`. The block latches all request context when it accepts the request, so later changes on the state inputs do not affect the sequence in progress. The control registers, the shadow bank, the status word and the address queue sit outside the block. The block updates them through write strobes with data. Instruction words come in through a single-word fetch port. When code translation was on, the fetch address first goes through an external translation lookup, which answers hit or miss.

Top module: `intr_entry_seq`

## Requirements
- R1: In the first cycle after acceptance, the block writes the status word that was present at acceptance to the saved-status register. Input changes after acceptance have no effect on any saved value.
- R2: In that same cycle, the block writes a new status word that has only bit 28 (wide mode) set. When the exception number is 1, bit 4 (machine-check mask) is also set.
- R3: In that same cycle, the block saves bits 63:32 of the front and back space identifiers to the saved space queue, and the full front and back offsets to the saved offset queue.
- R4: When bit 3 (Q) of the old status word is 0, the block writes neither the instruction register nor any shadow register, and makes no fetch or translation request.
- R5: For exception numbers 12 through 22 and 26 through 28, with Q set and bit 18 (C) clear, the block fetches the word at the front offset with bits 1:0 cleared and writes the fetched word to the instruction register.
- R6: For every other exception number, the instruction register is not written and no fetch or translation request is made.
- R7: For the numbers in R5 with Q and C both set, the block first looks up the cleared offset in the translation lookup. On a hit it fetches from the returned physical address. On a miss it writes zero to the instruction register and does not fetch.
- R8: With Q set, general registers 1, 8, 9, 16, 17, 24 and 25 are copied, one per cycle and in that order, into shadow entries 0 through 6.
- R9: The final step writes a front offset equal to the vector base plus 32 times the exception number (modulo 2^32), a back offset equal to the front plus 4, and zero to both space identifiers. `req_ack` is high for exactly that one cycle.
- R10: The block accepts a request only when idle. After `req_ack`, at least one cycle passes before the next save begins.
- R11: After reset, no write strobe, request or `req_ack` is active until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interruption request, held until acknowledged |
| req_excp | input | EXC_W | Exception number |
| req_ack | output | 1 | One-cycle acknowledge when the redirect is written |
| psw_cur | input | W | Current status word |
| iaoq_f_cur | input | W | Current front instruction offset |
| iaoq_b_cur | input | W | Current back instruction offset |
| iasq_f_cur | input | SPC_W | Current front space identifier |
| iasq_b_cur | input | SPC_W | Current back space identifier |
| vec_base | input | W | Vector table base |
| gr_rd_idx | output | GR_AW | General register read index |
| gr_rd_data | input | W | General register read data (same cycle) |
| xlate_req | output | 1 | Translation lookup request, held until done |
| xlate_space | output | SPC_W | Space identifier for the lookup |
| xlate_vaddr | output | W | Offset to translate |
| xlate_done | input | 1 | Lookup answered this cycle |
| xlate_hit | input | 1 | Lookup found a mapping |
| xlate_paddr | input | W | Physical address on a hit |
| fetch_req | output | 1 | Instruction word fetch request, held until acked |
| fetch_addr | output | W | Fetch address |
| fetch_ack | input | 1 | Fetch data valid this cycle |
| fetch_data | input | W | Fetched word |
| ipsw_we | output | 1 | Saved-status register write |
| ipsw_wd | output | W | Saved-status data |
| iisq_we | output | 1 | Saved space queue write |
| iisq_f_wd | output | SPC_W/2 | Front space, upper half |
| iisq_b_wd | output | SPC_W/2 | Back space, upper half |
| iioq_we | output | 1 | Saved offset queue write |
| iioq_f_wd | output | W | Front offset |
| iioq_b_wd | output | W | Back offset |
| iir_we | output | 1 | Instruction register write |
| iir_wd | output | W | Instruction register data |
| shadow_we | output | 1 | Shadow register write |
| shadow_idx | output | 3 | Shadow entry index |
| shadow_wd | output | W | Shadow data |
| psw_we | output | 1 | Status word write |
| psw_wd | output | W | New status word |
| iaq_we | output | 1 | Address queue redirect write |
| new_iaoq_f | output | W | New front offset |
| new_iaoq_b | output | W | New back offset |
| new_iasq_f | output | SPC_W | New front space |
| new_iasq_b | output | SPC_W | New back space |

## Verification
The bench builds the block with its defaults: 32-bit offsets, 64-bit spaces and a 5-bit exception number. With these widths the top vector number 31 added to a base near the top of the address space makes the vector sum wrap. The status-word bit positions stay at their defaults, so every combination of Q, C and the machine-check case comes from chosen input words. Fetch latencies of one to three cycles and a two-cycle lookup exercise the hold behaviour of both external ports. A back-to-back pair of requests shows the idle gap.

// File: rtl/intr_entry_pkg.sv
`timescale 1ns/1ps
package intr_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SAVE     = 3'd1,
    ST_XLATE    = 3'd2,
    ST_FETCH    = 3'd3,
    ST_SHADOW   = 3'd4,
    ST_REDIRECT = 3'd5
  } ie_state_e;

  // machine check code that also sets the mask bit
  localparam int unsigned EXC_MCHK   = 1;
  // exception ranges that capture the faulting word
  localparam int unsigned FC_A_LO    = 12;
  localparam int unsigned FC_A_HI    = 22;
  localparam int unsigned FC_B_LO    = 26;
  localparam int unsigned FC_B_HI    = 28;
  localparam int unsigned SHADOW_N   = 7;
  localparam int unsigned SHADOW_IW  = 3;

endpackage

// File: rtl/intr_entry_class.sv
`timescale 1ns/1ps
module intr_entry_class
  import intr_entry_pkg::*;
#(
  parameter int EXC_W = 5
) (
  input  logic [EXC_W-1:0] exc,
  output logic             fetch_cls,
  output logic             mchk
);

  logic [31:0] ex32;

  always_comb begin
    ex32      = 32'(exc);
    fetch_cls = ((ex32 >= FC_A_LO) && (ex32 <= FC_A_HI)) ||
                ((ex32 >= FC_B_LO) && (ex32 <= FC_B_HI));
    mchk      = (ex32 == EXC_MCHK);
  end

endmodule

// File: rtl/intr_entry_shadow.sv
`timescale 1ns/1ps
module intr_entry_shadow
  import intr_entry_pkg::*;
#(
  parameter int GR_AW = 5,
  parameter int IDX_W = SHADOW_IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  output logic [IDX_W-1:0] sh_idx,
  output logic [GR_AW-1:0] gr_idx,
  output logic             sh_last
);

  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cnt_d;
  logic [IDX_W-1:0] slot;

  always_comb begin
    cnt_d = active ? (cnt_q + IDX_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // slot k+1 maps to register pair base 8*(slot/2) plus slot parity
  always_comb begin
    slot    = cnt_q + IDX_W'(1);
    gr_idx  = GR_AW'({slot[IDX_W-1:1], 3'b000}) | GR_AW'(slot[0]);
    sh_idx  = cnt_q;
    sh_last = (cnt_q == IDX_W'(SHADOW_N - 1));
  end

endmodule

// File: rtl/intr_entry_fsm.sv
`timescale 1ns/1ps
module intr_entry_fsm
  import intr_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      old_q,
  input  logic      old_c,
  input  logic      fetch_cls,
  input  logic      xlate_done,
  input  logic      xlate_hit,
  input  logic      fetch_ack,
  input  logic      sh_last,
  output ie_state_e state,
  output logic      accept
);

  ie_state_e st_q;
  ie_state_e st_d;

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_d   = ST_SAVE;
        end
      end
      ST_SAVE: begin
        if (old_q && fetch_cls) begin
          st_d = old_c ? ST_XLATE : ST_FETCH;
        end else if (old_q) begin
          st_d = ST_SHADOW;
        end else begin
          st_d = ST_REDIRECT;
        end
      end
      ST_XLATE: begin
        if (xlate_done) begin
          st_d = xlate_hit ? ST_FETCH : ST_SHADOW;
        end
      end
      ST_FETCH: begin
        if (fetch_ack) begin
          st_d = ST_SHADOW;
        end
      end
      ST_SHADOW: begin
        if (sh_last) begin
          st_d = ST_REDIRECT;
        end
      end
      ST_REDIRECT: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/intr_entry_seq.sv
`timescale 1ns/1ps
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int W         = 32,
  parameter int SPC_W     = 64,
  parameter int EXC_W     = 5,
  parameter int GR_AW     = 5,
  parameter int PSW_Q_BIT = 3,
  parameter int PSW_M_BIT = 4,
  parameter int PSW_C_BIT = 18,
  parameter int PSW_W_BIT = 28,
  parameter int VEC_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [EXC_W-1:0]     req_excp,
  output logic                 req_ack,
  input  logic [W-1:0]         psw_cur,
  input  logic [W-1:0]         iaoq_f_cur,
  input  logic [W-1:0]         iaoq_b_cur,
  input  logic [SPC_W-1:0]     iasq_f_cur,
  input  logic [SPC_W-1:0]     iasq_b_cur,
  input  logic [W-1:0]         vec_base,
  output logic [GR_AW-1:0]     gr_rd_idx,
  input  logic [W-1:0]         gr_rd_data,
  output logic                 xlate_req,
  output logic [SPC_W-1:0]     xlate_space,
  output logic [W-1:0]         xlate_vaddr,
  input  logic                 xlate_done,
  input  logic                 xlate_hit,
  input  logic [W-1:0]         xlate_paddr,
  output logic                 fetch_req,
  output logic [W-1:0]         fetch_addr,
  input  logic                 fetch_ack,
  input  logic [W-1:0]         fetch_data,
  output logic                 ipsw_we,
  output logic [W-1:0]         ipsw_wd,
  output logic                 iisq_we,
  output logic [SPC_W/2-1:0]   iisq_f_wd,
  output logic [SPC_W/2-1:0]   iisq_b_wd,
  output logic                 iioq_we,
  output logic [W-1:0]         iioq_f_wd,
  output logic [W-1:0]         iioq_b_wd,
  output logic                 iir_we,
  output logic [W-1:0]         iir_wd,
  output logic                 shadow_we,
  output logic [SHADOW_IW-1:0] shadow_idx,
  output logic [W-1:0]         shadow_wd,
  output logic                 psw_we,
  output logic [W-1:0]         psw_wd,
  output logic                 iaq_we,
  output logic [W-1:0]         new_iaoq_f,
  output logic [W-1:0]         new_iaoq_b,
  output logic [SPC_W-1:0]     new_iasq_f,
  output logic [SPC_W-1:0]     new_iasq_b
);

  localparam int HALF_W = SPC_W / 2;

  ie_state_e        state;
  logic             accept;
  logic             fetch_cls;
  logic             mchk;
  logic             sh_last;
  logic             xl_hit_now;

  logic [EXC_W-1:0] exc_q;
  logic [W-1:0]     psw_q;
  logic [W-1:0]     iaoq_f_q;
  logic [W-1:0]     iaoq_b_q;
  logic [SPC_W-1:0] iasq_f_q;
  logic [SPC_W-1:0] iasq_b_q;
  logic [W-1:0]     vbase_q;
  logic [W-1:0]     fa_q;
  logic [W-1:0]     word_addr;

  // request context, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q    <= '0;
      psw_q    <= '0;
      iaoq_f_q <= '0;
      iaoq_b_q <= '0;
      iasq_f_q <= '0;
      iasq_b_q <= '0;
      vbase_q  <= '0;
    end else if (accept) begin
      exc_q    <= req_excp;
      psw_q    <= psw_cur;
      iaoq_f_q <= iaoq_f_cur;
      iaoq_b_q <= iaoq_b_cur;
      iasq_f_q <= iasq_f_cur;
      iasq_b_q <= iasq_b_cur;
      vbase_q  <= vec_base;
    end
  end

  assign word_addr  = {iaoq_f_cur[W-1:2], 2'b00};
  assign xl_hit_now = (state == ST_XLATE) && xlate_done && xlate_hit;

  // fetch address: word-aligned offset, replaced by a translated address on a hit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0;
    end else if (accept) begin
      fa_q <= word_addr;
    end else if (xl_hit_now) begin
      fa_q <= xlate_paddr;
    end
  end

  intr_entry_class #(.EXC_W(EXC_W)) u_class (
    .exc       (exc_q),
    .fetch_cls (fetch_cls),
    .mchk      (mchk)
  );

  intr_entry_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .old_q      (psw_q[PSW_Q_BIT]),
    .old_c      (psw_q[PSW_C_BIT]),
    .fetch_cls  (fetch_cls),
    .xlate_done (xlate_done),
    .xlate_hit  (xlate_hit),
    .fetch_ack  (fetch_ack),
    .sh_last    (sh_last),
    .state      (state),
    .accept     (accept)
  );

  intr_entry_shadow #(.GR_AW(GR_AW), .IDX_W(SHADOW_IW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state == ST_SHADOW),
    .sh_idx  (shadow_idx),
    .gr_idx  (gr_rd_idx),
    .sh_last (sh_last)
  );

  // save cycle
  always_comb begin
    ipsw_we   = (state == ST_SAVE);
    ipsw_wd   = psw_q;
    iisq_we   = (state == ST_SAVE);
    iisq_f_wd = iasq_f_q[SPC_W-1:HALF_W];
    iisq_b_wd = iasq_b_q[SPC_W-1:HALF_W];
    iioq_we   = (state == ST_SAVE);
    iioq_f_wd = iaoq_f_q;
    iioq_b_wd = iaoq_b_q;
    psw_we    = (state == ST_SAVE);
    psw_wd    = (W'(1) << PSW_W_BIT) | (mchk ? (W'(1) << PSW_M_BIT) : '0);
  end

  // faulting word capture
  always_comb begin
    xlate_req   = (state == ST_XLATE);
    xlate_space = iasq_f_q;
    xlate_vaddr = {iaoq_f_q[W-1:2], 2'b00};
    fetch_req   = (state == ST_FETCH);
    fetch_addr  = fa_q;
    iir_we      = ((state == ST_XLATE) && xlate_done && !xlate_hit) ||
                  ((state == ST_FETCH) && fetch_ack);
    iir_wd      = (state == ST_FETCH) ? fetch_data : '0;
  end

  // shadow copy and redirect
  always_comb begin
    shadow_we  = (state == ST_SHADOW);
    shadow_wd  = gr_rd_data;
    iaq_we     = (state == ST_REDIRECT);
    req_ack    = (state == ST_REDIRECT);
    new_iaoq_f = vbase_q + (W'(exc_q) << VEC_SHIFT);
    new_iaoq_b = new_iaoq_f + W'(4);
    new_iasq_f = '0;
    new_iasq_b = '0;
  end

endmodule

// File: rtl/intr_entry_seq_chk.sv
`timescale 1ns/1ps
module intr_entry_seq_chk #(
  parameter int W         = 32,
  parameter int SPC_W     = 64,
  parameter int PSW_Q_BIT = 3,
  parameter int PSW_M_BIT = 4,
  parameter int PSW_W_BIT = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ack,
  input logic             ipsw_we,
  input logic             psw_we,
  input logic [W-1:0]     psw_wd,
  input logic [W-1:0]     psw_q,
  input logic             iir_we,
  input logic             shadow_we,
  input logic [2:0]       shadow_idx,
  input logic             xlate_req,
  input logic             xlate_done,
  input logic [W-1:0]     xlate_vaddr,
  input logic             fetch_req,
  input logic             fetch_ack,
  input logic [W-1:0]     fetch_addr,
  input logic             iaq_we,
  input logic [W-1:0]     new_iaoq_f,
  input logic [W-1:0]     new_iaoq_b,
  input logic [SPC_W-1:0] new_iasq_f,
  input logic [SPC_W-1:0] new_iasq_b
);

  localparam logic [W-1:0] PSW_ALLOWED = (W'(1) << PSW_W_BIT) | (W'(1) << PSW_M_BIT);

  p_save_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ipsw_we |=> !ipsw_we);

  p_psw_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |-> (((psw_wd & ~PSW_ALLOWED) == '0) && psw_wd[PSW_W_BIT]));

  p_no_save_without_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_we || shadow_we) |-> psw_q[PSW_Q_BIT]);

  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

  p_xlate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_req && !xlate_done) |=> (xlate_req && $stable(xlate_vaddr)));

  p_shadow_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_we && (shadow_idx != 3'd0)) |->
      ($past(shadow_we) && (shadow_idx == $past(shadow_idx) + 3'd1)));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (iaq_we && (new_iaoq_b == new_iaoq_f + W'(4)) &&
                 (new_iasq_f == '0) && (new_iasq_b == '0)));

  p_idle_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !ipsw_we);

endmodule

bind intr_entry_seq intr_entry_seq_chk #(
  .W(W), .SPC_W(SPC_W), .PSW_Q_BIT(PSW_Q_BIT), .PSW_M_BIT(PSW_M_BIT), .PSW_W_BIT(PSW_W_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .ipsw_we(ipsw_we),
  .psw_we(psw_we), .psw_wd(psw_wd), .psw_q(psw_q), .iir_we(iir_we),
  .shadow_we(shadow_we), .shadow_idx(shadow_idx), .xlate_req(xlate_req),
  .xlate_done(xlate_done), .xlate_vaddr(xlate_vaddr), .fetch_req(fetch_req),
  .fetch_ack(fetch_ack), .fetch_addr(fetch_addr), .iaq_we(iaq_we),
  .new_iaoq_f(new_iaoq_f), .new_iaoq_b(new_iaoq_b),
  .new_iasq_f(new_iasq_f), .new_iasq_b(new_iasq_b)
);

// File: tb/intr_entry_seq_tb.sv
`timescale 1ns/1ps
module intr_entry_seq_tb;

  localparam int K_IPSW = 0, K_ISQ = 1, K_IOQ = 2, K_PSW = 3, K_IIR = 4, K_SHD = 5, K_RED = 6;
  localparam logic [31:0] B_Q = 32'h0000_0008, B_M = 32'h0000_0010;
  localparam logic [31:0] B_C = 32'h0004_0000, B_W = 32'h1000_0000;
  localparam logic [31:0] XL_OFS = 32'h1000_0000, MEM_KEY = 32'hC0DE_0000;

  typedef struct {
    int          kind;
    logic [63:0] a;
    logic [63:0] b;
    string       rq;
  } exp_t;

  logic clk, rst_n;
  logic req_valid, req_ack;
  logic [4:0] req_excp;
  logic [31:0] psw_cur, iaoq_f_cur, iaoq_b_cur, vec_base;
  logic [63:0] iasq_f_cur, iasq_b_cur;
  logic [4:0] gr_rd_idx;
  logic [31:0] gr_rd_data;
  logic xlate_req, xlate_done, xlate_hit;
  logic [63:0] xlate_space;
  logic [31:0] xlate_vaddr, xlate_paddr;
  logic fetch_req, fetch_ack;
  logic [31:0] fetch_addr, fetch_data;
  logic ipsw_we, iisq_we, iioq_we, iir_we, shadow_we, psw_we, iaq_we;
  logic [31:0] ipsw_wd, iioq_f_wd, iioq_b_wd, iir_wd, shadow_wd, psw_wd;
  logic [31:0] iisq_f_wd, iisq_b_wd, new_iaoq_f, new_iaoq_b;
  logic [2:0] shadow_idx;
  logic [63:0] new_iasq_f, new_iasq_b;

  int errors = 0, checks = 0;
  int n_fetch = 0, n_xlate = 0, fcnt = 0, xcnt = 0, f_lat = 1;
  logic xl_miss = 1'b0;
  logic [31:0] gr_seed = '0;
  bit done = 0;
  exp_t sb[$];

  intr_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_excp(req_excp), .req_ack(req_ack),
    .psw_cur(psw_cur), .iaoq_f_cur(iaoq_f_cur), .iaoq_b_cur(iaoq_b_cur),
    .iasq_f_cur(iasq_f_cur), .iasq_b_cur(iasq_b_cur), .vec_base(vec_base),
    .gr_rd_idx(gr_rd_idx), .gr_rd_data(gr_rd_data),
    .xlate_req(xlate_req), .xlate_space(xlate_space), .xlate_vaddr(xlate_vaddr),
    .xlate_done(xlate_done), .xlate_hit(xlate_hit), .xlate_paddr(xlate_paddr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .ipsw_we(ipsw_we), .ipsw_wd(ipsw_wd), .iisq_we(iisq_we), .iisq_f_wd(iisq_f_wd),
    .iisq_b_wd(iisq_b_wd), .iioq_we(iioq_we), .iioq_f_wd(iioq_f_wd), .iioq_b_wd(iioq_b_wd),
    .iir_we(iir_we), .iir_wd(iir_wd), .shadow_we(shadow_we), .shadow_idx(shadow_idx),
    .shadow_wd(shadow_wd), .psw_we(psw_we), .psw_wd(psw_wd), .iaq_we(iaq_we),
    .new_iaoq_f(new_iaoq_f), .new_iaoq_b(new_iaoq_b),
    .new_iasq_f(new_iasq_f), .new_iasq_b(new_iasq_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // general register file model
  assign gr_rd_data = 32'h6000_0000 + 32'(gr_rd_idx) * 32'd257 + gr_seed;

  // fetch responder
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_ack <= 1'b0; fetch_data <= '0; fcnt <= 0;
    end else if (fetch_ack) begin
      fetch_ack <= 1'b0;
    end else if (fetch_req) begin
      if (fcnt >= f_lat - 1) begin
        fetch_ack <= 1'b1; fetch_data <= fetch_addr ^ MEM_KEY; fcnt <= 0; n_fetch <= n_fetch + 1;
      end else fcnt <= fcnt + 1;
    end
  end

  // translation responder, two-cycle answer
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlate_done <= 1'b0; xlate_hit <= 1'b0; xlate_paddr <= '0; xcnt <= 0;
    end else if (xlate_done) begin
      xlate_done <= 1'b0;
    end else if (xlate_req) begin
      if (xcnt >= 1) begin
        xlate_done <= 1'b1; xlate_hit <= !xl_miss; xlate_paddr <= xlate_vaddr + XL_OFS;
        xcnt <= 0; n_xlate <= n_xlate + 1;
      end else xcnt <= xcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [63:0] a, input logic [63:0] b, input string rq);
    exp_t e;
    e.kind = kind; e.a = a; e.b = b; e.rq = rq;
    sb.push_back(e);
  endtask

  task automatic pop_cmp(input int kind, input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    if (sb.size() == 0) begin
      chk(1'b0, "R4 R6 unexpected write", 64'(kind), 64'hFFFF);
    end else begin
      e = sb.pop_front();
      chk(e.kind == kind, e.rq, 64'(kind), 64'(e.kind));
      if (e.kind == kind) begin
        chk(e.a == a, e.rq, a, e.a);
        chk(e.b == b, e.rq, b, e.b);
      end
    end
  endtask

  // monitor: compare every write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ipsw_we)   pop_cmp(K_IPSW, 64'(ipsw_wd), 64'd0);
      if (iisq_we)   pop_cmp(K_ISQ, 64'(iisq_f_wd), 64'(iisq_b_wd));
      if (iioq_we)   pop_cmp(K_IOQ, 64'(iioq_f_wd), 64'(iioq_b_wd));
      if (psw_we)    pop_cmp(K_PSW, 64'(psw_wd), 64'd0);
      if (iir_we)    pop_cmp(K_IIR, 64'(iir_wd), 64'd0);
      if (shadow_we) pop_cmp(K_SHD, 64'(shadow_idx), 64'(shadow_wd));
      if (iaq_we) begin
        pop_cmp(K_RED, 64'(new_iaoq_f), 64'(new_iaoq_b));
        chk((new_iasq_f == '0) && (new_iasq_b == '0), "R9 spaces zero", new_iasq_f | new_iasq_b, 64'd0);
      end
      if (req_ack != iaq_we) chk(1'b0, "R9 ack with redirect", 64'(req_ack), 64'(iaq_we));
    end
  end

  function automatic bit fcls(input int e);
    return (e >= 12 && e <= 22) || (e >= 26 && e <= 28);
  endfunction

  task automatic run_case(input int exc, input logic [31:0] psw, input logic [31:0] of,
                          input logic [31:0] ob, input logic [63:0] sf, input logic [63:0] sb_,
                          input logic [31:0] iv, input bit miss, input logic [31:0] seed,
                          input int lat, input bit keep);
    bit q, c, fc;
    int f0, x0, ef, ex;
    logic [31:0] va, vec;
    int gl[7] = '{1, 8, 9, 16, 17, 24, 25};
    @(negedge clk);
    q = psw[3]; c = psw[18]; fc = fcls(exc);
    req_excp = 5'(exc); psw_cur = psw; iaoq_f_cur = of; iaoq_b_cur = ob;
    iasq_f_cur = sf; iasq_b_cur = sb_; vec_base = iv;
    xl_miss = miss; gr_seed = seed; f_lat = lat;
    f0 = n_fetch; x0 = n_xlate;
    push(K_IPSW, 64'(psw), 64'd0, "R1 saved status");
    push(K_ISQ, 64'(sf[63:32]), 64'(sb_[63:32]), "R3 space queue");
    push(K_IOQ, 64'(of), 64'(ob), "R3 offset queue R10 latched");
    push(K_PSW, 64'(B_W | ((exc == 1) ? B_M : 32'd0)), 64'd0, "R2 new status");
    va = {of[31:2], 2'b00};
    if (q && fc) begin
      if (c && miss) push(K_IIR, 64'd0, 64'd0, "R7 miss gives zero");
      else if (c)    push(K_IIR, 64'((va + XL_OFS) ^ MEM_KEY), 64'd0, "R7 translated fetch");
      else           push(K_IIR, 64'(va ^ MEM_KEY), 64'd0, "R5 direct fetch");
    end
    if (q) begin
      for (int k = 0; k < 7; k++)
        push(K_SHD, 64'(k), 64'(32'h6000_0000 + 32'(gl[k]) * 32'd257 + seed), "R8 shadow copy");
    end
    vec = iv + 32'(exc) * 32'd32;
    push(K_RED, 64'(vec), 64'(vec + 32'd4), "R9 vector redirect");
    ef = (q && fc && !(c && miss)) ? 1 : 0;
    ex = (q && fc && c) ? 1 : 0;
    req_valid = 1'b1;
    do @(negedge clk); while (!ipsw_we);
    // scramble context after acceptance (R10)
    psw_cur = ~psw; iaoq_f_cur = ~of; iaoq_b_cur = ~ob; iasq_f_cur = ~sf; iasq_b_cur = ~sb_;
    vec_base = ~iv;
    do @(negedge clk); while (!req_ack);
    if (!keep) req_valid = 1'b0;
    chk((n_fetch - f0) == ef, "R4 R5 R6 R7 fetch count", 64'(n_fetch - f0), 64'(ef));
    chk((n_xlate - x0) == ex, "R4 R6 R7 lookup count", 64'(n_xlate - x0), 64'(ex));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_excp = '0;
    psw_cur = '0; iaoq_f_cur = '0; iaoq_b_cur = '0; iasq_f_cur = '0; iasq_b_cur = '0; vec_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!req_ack && !ipsw_we && !psw_we && !iaq_we, "R11 idle after reset", 64'(req_ack), 64'd0);
      chk(!fetch_req && !xlate_req && !shadow_we && !iir_we, "R11 no requests", 64'(fetch_req), 64'd0);
    end
    // R4: Q clear, external-style number
    run_case(4, 32'h0000_FF00, 32'h0000_2003, 32'h0000_2007, 64'h1111_2222_3333_4444,
             64'h5555_6666_7777_8888, 32'h0001_0000, 0, 32'd0, 1, 0);
    // R2: machine check with Q set, no word capture
    run_case(1, B_Q | 32'h0000_0100, 32'h0000_4000, 32'h0000_4004, 64'hAAAA_0000_0000_0001,
             64'hBBBB_0000_0000_0002, 32'h0002_0000, 0, 32'd5, 1, 0);
    // R5: fetch class, translation off
    run_case(12, B_Q, 32'h0000_1237, 32'h0000_123B, 64'h0000_00AA_0000_0000,
             64'h0000_00BB_0000_0000, 32'h0003_0000, 0, 32'd9, 3, 0);
    // R7: translation hit
    run_case(15, B_Q | B_C, 32'h0040_0102, 32'h0040_0106, 64'h0000_0010_0000_0000,
             64'h0000_0020_0000_0000, 32'h0004_0000, 0, 32'd11, 2, 0);
    // R7: translation miss
    run_case(28, B_Q | B_C, 32'h0050_0001, 32'h0050_0005, 64'h0000_0030_0000_0000,
             64'h0000_0040_0000_0000, 32'h0005_0000, 1, 32'd13, 1, 0);
    // R6: illegal-instruction class leaves word register alone
    run_case(8, B_Q | B_C, 32'h0060_0000, 32'h0060_0004, 64'h0, 64'h0, 32'h0006_0000, 0, 32'd17, 1, 0);
    // R6: break number with translation on
    run_case(9, B_Q | B_C, 32'h0060_0010, 32'h0060_0014, 64'h1, 64'h2, 32'h0006_1000, 0, 32'd19, 1, 0);
    // R4: fetch class but Q clear
    run_case(22, B_C, 32'h0070_0000, 32'h0070_0004, 64'h3, 64'h4, 32'h0007_0000, 0, 32'd0, 1, 0);
    // R9: top number with wrapping vector sum
    run_case(31, B_Q, 32'hFFFF_FFFC, 32'h0000_0000, 64'hFFFF_FFFF_0000_0000,
             64'h8000_0000_FFFF_FFFF, 32'hFFFF_FF00, 0, 32'd23, 1, 0);
    // R10: back-to-back requests, second held until idle
    run_case(26, B_Q, 32'h0080_0008, 32'h0080_000C, 64'h0000_0077_0000_0000,
             64'h0000_0088_0000_0000, 32'h0008_0000, 0, 32'd29, 2, 1);
    run_case(27, B_Q | B_C, 32'h0090_0006, 32'h0090_000A, 64'h0000_0099_0000_0000,
             64'h0000_00AA_0000_0000, 32'h0009_0000, 1, 32'd31, 1, 0);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R9 all sequences completed", 64'(sb.size()), 64'd0);
    chk(!req_ack && !ipsw_we, "R10 idle after last ack", 64'(req_ack), 64'd0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule